// File: doc/BRIEF.md
# SAR ADC Sequencer with Window Compare

This block is the digital half of a 10-bit successive-approximation converter. It picks one conversion-start event out of six possible sources, then runs a binary search. Each step drives a trial code to an external DAC and reads back a single comparator bit. When the search is over, the block latches the result, raises a done flag and, if enabled, pulses an end-of-conversion interrupt.

Each finished result also goes to a window comparator with inclusive low and high limits. The comparator can be set to flag results that land inside the range or results that land outside it. Its interrupt flag stays set until a dedicated clear input drops it. A continuous mode starts a new conversion as soon as the previous one ends, so a voltage can be watched in the background and the block interrupts only when the window condition is met.

All configuration comes in on plain input ports. The analog front end, the DAC, the comparator and any register file sit outside the block.

Top module: `sar_adc_seq`

## Requirements
- R1: `startSel` picks the start event. 3'b000 is a high level on `swStart`, 3'b001 is timer 0, 3'b011 is timer 1, 3'b010 is timer 2, 3'b101 is timer 3, and 3'b100 is the external start pin. Events from any source that is not selected do nothing.
- R2: Codes 3'b110 and 3'b111 start no conversion from any input.
- R3: While `enable` is low, every trigger is ignored. Dropping `enable` during a conversion aborts it: `busy` falls and nothing is latched.
- R4: The search runs MSB first. The first trial code is 10'b1000000000. On each step the trial bit is kept if `cmpIn` is high and cleared if it is low, and the next lower bit is set. One step happens every `CLK_DIV` clocks, and `busy` stays high for exactly 10*`CLK_DIV` cycles.
- R5: `busy` rises on the clock edge that accepts a trigger and falls on the edge that latches the result. Triggers that arrive while `busy` is high are ignored.
- R6: `result` changes only on the edge that finishes a conversion. On that edge `done` goes high, and `done` goes low again when the next conversion starts.
- R7: `eocIrq` is a one-cycle pulse on the completion edge, and only when `eocIntEn` is high.
- R8: A result is inside the window when `winLow` ≤ result ≤ `winHigh`. When `winIntEn` is high and the result meets the chosen condition (`winInside`=1 for inside, 0 for outside), `winIrq` is set. It stays set until `winClr`.
- R9: The timer and external inputs start a conversion only on a rising edge; holding them high does not start another. The external pin passes through a two-flop synchroniser first.
- R10: With `contMode` high and `enable` high, a new conversion starts on the first idle cycle, without any trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Converter enable |
| contMode | input | 1 | Back-to-back conversion mode |
| startSel | input | 3 | Start source code |
| swStart | input | 1 | Software start request |
| tmr0Ovf | input | 1 | Timer 0 overflow |
| tmr1Ovf | input | 1 | Timer 1 overflow |
| tmr2Ovf | input | 1 | Timer 2 overflow |
| tmr3Ovf | input | 1 | Timer 3 overflow |
| extStart | input | 1 | Asynchronous external start pin |
| cmpIn | input | 1 | Comparator bit, high when input ≥ trial code |
| eocIntEn | input | 1 | End-of-conversion interrupt enable |
| winIntEn | input | 1 | Window interrupt enable |
| winInside | input | 1 | 1 flags inside the window, 0 flags outside |
| winLow | input | 10 | Lower window bound, inclusive |
| winHigh | input | 10 | Upper window bound, inclusive |
| winClr | input | 1 | Clears the window interrupt flag |
| dacCode | output | 10 | Trial code for the DAC |
| busy | output | 1 | Conversion in progress |
| result | output | 10 | Last completed result |
| done | output | 1 | Conversion complete flag |
| eocIrq | output | 1 | End-of-conversion interrupt pulse |
| winIrq | output | 1 | Sticky window interrupt flag |

## Verification
The bench models the comparator as an ideal analog input, so every correct search must return that input exactly. A wrong bit-keep decision shows up as a result that differs from the modelled value as soon as `done` rises. A corrupted step counter or divider moves the falling edge of `busy` away from the expected 10*`CLK_DIV` cycles, and the bench sees this within one conversion. A bad trigger-select or edge-detect state shows as `busy` rising when it should stay low, or staying low when it should rise, within a few cycles of the stimulus. A broken window or sticky-flag state shows at `winIrq` on the completion cycle or at the following clear.

// File: rtl/sar_adc_pkg.sv
`timescale 1ns/1ps
package sar_adc_pkg;

  // Strobes from control to datapath, one cycle each.
  typedef struct packed {
    logic start;  // trigger accepted, load MSB trial
    logic step;   // resolve current trial bit
    logic last;   // final step, latch result
  } sarStrobe_t;

  // Start source codes; the encoding is externally visible.
  typedef enum logic [2:0] {
    SRC_SW   = 3'b000,
    SRC_TMR0 = 3'b001,
    SRC_TMR2 = 3'b010,
    SRC_TMR1 = 3'b011,
    SRC_EXT  = 3'b100,
    SRC_TMR3 = 3'b101
  } startSrc_e;

endpackage

// File: rtl/sar_adc_ctrl.sv
`timescale 1ns/1ps
module sar_adc_ctrl
  import sar_adc_pkg::*;
#(
  parameter int DATA_W  = 10,
  parameter int CLK_DIV = 4,
  parameter int N_TMR   = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             contMode,
  input  logic [2:0]       startSel,
  input  logic             swStart,
  input  logic [N_TMR-1:0] tmrOvf,
  input  logic             extStart,
  output logic             busy,
  output sarStrobe_t       strobe
);

  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int CNT_W = $clog2(DATA_W);

  // Rising-edge detection per timer input (R9)
  logic [N_TMR-1:0] tmrPrev;
  logic [N_TMR-1:0] tmrRise;

  genvar gi;
  generate
    for (gi = 0; gi < N_TMR; gi++) begin : g_tmrEdge
      always_ff @(posedge clk) begin
        if (!rstN) tmrPrev[gi] <= 1'b0;
        else       tmrPrev[gi] <= tmrOvf[gi];
      end
      assign tmrRise[gi] = tmrOvf[gi] & ~tmrPrev[gi];
    end
  endgenerate

  // Two-flop synchroniser then edge detect for the external pin (R9)
  logic extSync1, extSync2, extPrev, extRise;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      extSync1 <= 1'b0;
      extSync2 <= 1'b0;
      extPrev  <= 1'b0;
    end else begin
      extSync1 <= extStart;
      extSync2 <= extSync1;
      extPrev  <= extSync2;
    end
  end
  assign extRise = extSync2 & ~extPrev;

  // Source select (R1, R2)
  logic selTrig;
  always_comb begin
    unique case (startSel)
      SRC_SW:   selTrig = swStart;
      SRC_TMR0: selTrig = tmrRise[0];
      SRC_TMR1: selTrig = tmrRise[1];
      SRC_TMR2: selTrig = tmrRise[2];
      SRC_TMR3: selTrig = tmrRise[3];
      SRC_EXT:  selTrig = extRise;
      default:  selTrig = 1'b0;
    endcase
  end

  logic [DIV_W-1:0] divCnt;
  logic [CNT_W-1:0] bitCnt;
  logic             divWrap;

  assign divWrap      = busy && (divCnt == DIV_W'(CLK_DIV - 1));
  assign strobe.start = enable && !busy && (selTrig || contMode);
  assign strobe.step  = enable && divWrap;
  assign strobe.last  = strobe.step && (bitCnt == CNT_W'(DATA_W - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy   <= 1'b0;
      divCnt <= '0;
      bitCnt <= '0;
    end else if (!enable) begin
      busy   <= 1'b0;
      divCnt <= '0;
      bitCnt <= '0;
    end else if (strobe.start) begin
      busy   <= 1'b1;
      divCnt <= '0;
      bitCnt <= '0;
    end else if (busy) begin
      divCnt <= divWrap ? '0 : divCnt + 1'b1;
      if (strobe.step) bitCnt <= bitCnt + 1'b1;
      if (strobe.last) busy <= 1'b0;
    end
  end

endmodule

// File: rtl/sar_adc_window.sv
`timescale 1ns/1ps
module sar_adc_window #(
  parameter int DATA_W = 10
) (
  input  logic [DATA_W-1:0] value,
  input  logic [DATA_W-1:0] lowLim,
  input  logic [DATA_W-1:0] highLim,
  input  logic              flagInside,
  output logic              hit
);

  logic inRange;
  assign inRange = (value >= lowLim) && (value <= highLim);
  assign hit     = flagInside ? inRange : !inRange;

endmodule

// File: rtl/sar_adc_datapath.sv
`timescale 1ns/1ps
module sar_adc_datapath
  import sar_adc_pkg::*;
#(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  sarStrobe_t        strobe,
  input  logic              cmpIn,
  input  logic              eocIntEn,
  input  logic              winIntEn,
  input  logic              winInside,
  input  logic [DATA_W-1:0] winLow,
  input  logic [DATA_W-1:0] winHigh,
  input  logic              winClr,
  output logic [DATA_W-1:0] dacCode,
  output logic [DATA_W-1:0] result,
  output logic              done,
  output logic              eocIrq,
  output logic              winIrq
);

  localparam logic [DATA_W-1:0] MSB_MASK = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] trial, mask, nextTrial;
  logic              winHit;

  // Resolve current bit, then set the next lower trial bit (R4)
  always_comb begin
    nextTrial = trial;
    if (!cmpIn) nextTrial = nextTrial & ~mask;
    nextTrial = nextTrial | (mask >> 1);
  end

  sar_adc_window #(.DATA_W(DATA_W)) u_window (
    .value      (nextTrial),
    .lowLim     (winLow),
    .highLim    (winHigh),
    .flagInside (winInside),
    .hit        (winHit)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      trial  <= '0;
      mask   <= '0;
      result <= '0;
      done   <= 1'b0;
      eocIrq <= 1'b0;
      winIrq <= 1'b0;
    end else begin
      eocIrq <= strobe.last && eocIntEn;
      if (strobe.start) begin
        trial <= MSB_MASK;
        mask  <= MSB_MASK;
        done  <= 1'b0;
      end else if (strobe.step) begin
        trial <= nextTrial;
        mask  <= mask >> 1;
      end
      if (strobe.last) begin
        result <= nextTrial;
        done   <= 1'b1;
      end
      if (strobe.last && winIntEn && winHit) winIrq <= 1'b1;
      else if (winClr)                       winIrq <= 1'b0;
    end
  end

  assign dacCode = trial;

endmodule

// File: rtl/sar_adc_seq.sv
`timescale 1ns/1ps
module sar_adc_seq
  import sar_adc_pkg::*;
#(
  parameter int DATA_W  = 10,
  parameter int CLK_DIV = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              contMode,
  input  logic [2:0]        startSel,
  input  logic              swStart,
  input  logic              tmr0Ovf,
  input  logic              tmr1Ovf,
  input  logic              tmr2Ovf,
  input  logic              tmr3Ovf,
  input  logic              extStart,
  input  logic              cmpIn,
  input  logic              eocIntEn,
  input  logic              winIntEn,
  input  logic              winInside,
  input  logic [DATA_W-1:0] winLow,
  input  logic [DATA_W-1:0] winHigh,
  input  logic              winClr,
  output logic [DATA_W-1:0] dacCode,
  output logic              busy,
  output logic [DATA_W-1:0] result,
  output logic              done,
  output logic              eocIrq,
  output logic              winIrq
);

  sarStrobe_t strobe;

  sar_adc_ctrl #(.DATA_W(DATA_W), .CLK_DIV(CLK_DIV), .N_TMR(4)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .enable   (enable),
    .contMode (contMode),
    .startSel (startSel),
    .swStart  (swStart),
    .tmrOvf   ({tmr3Ovf, tmr2Ovf, tmr1Ovf, tmr0Ovf}),
    .extStart (extStart),
    .busy     (busy),
    .strobe   (strobe)
  );

  sar_adc_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .cmpIn     (cmpIn),
    .eocIntEn  (eocIntEn),
    .winIntEn  (winIntEn),
    .winInside (winInside),
    .winLow    (winLow),
    .winHigh   (winHigh),
    .winClr    (winClr),
    .dacCode   (dacCode),
    .result    (result),
    .done      (done),
    .eocIrq    (eocIrq),
    .winIrq    (winIrq)
  );

endmodule

// File: rtl/sar_adc_seq_chk.sv
`timescale 1ns/1ps
module sar_adc_seq_chk #(
  parameter int DATA_W = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              enable,
  input logic              contMode,
  input logic [2:0]        startSel,
  input logic              eocIntEn,
  input logic              winClr,
  input logic [DATA_W-1:0] dacCode,
  input logic              busy,
  input logic [DATA_W-1:0] result,
  input logic              done,
  input logic              eocIrq,
  input logic              winIrq
);

  p_reserved_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    (startSel[2:1] == 2'b11 && !busy && !contMode) |=> !busy);

  p_disabled_idle_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!enable && !busy) |=> !busy);

  p_msb_first_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (dacCode == {1'b1, {(DATA_W-1){1'b0}}}));

  p_busy_done_excl_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done));

  p_result_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(done && !$past(done)) |-> $stable(result));

  p_eoc_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    eocIrq |-> ($fell(busy) && done && $past(eocIntEn)));

  p_win_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(winIrq) && !$past(winClr)) |-> winIrq);

endmodule

bind sar_adc_seq sar_adc_seq_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_sar_adc_seq.sv
`timescale 1ns/1ps
module tb_sar_adc_seq;

  localparam int W   = 10;
  localparam int DIV = 4;
  localparam int NV  = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0, contMode = 1'b0;
  logic [2:0] startSel = 3'b000;
  logic swStart = 0, tmr0Ovf = 0, tmr1Ovf = 0, tmr2Ovf = 0, tmr3Ovf = 0, extStart = 0;
  logic eocIntEn = 0, winIntEn = 0, winInside = 0, winClr = 0;
  logic [W-1:0] winLow = '0, winHigh = '0;
  logic [W-1:0] vin = '0;
  logic cmpIn;
  logic [W-1:0] dacCode, result;
  logic busy, done, eocIrq, winIrq;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  // Ideal comparator: high when the input is at or above the trial code
  assign cmpIn = (dacCode <= vin);

  sar_adc_seq #(.DATA_W(W), .CLK_DIV(DIV)) dut (
    .clk(clk), .rstN(rstN), .enable(enable), .contMode(contMode),
    .startSel(startSel), .swStart(swStart), .tmr0Ovf(tmr0Ovf),
    .tmr1Ovf(tmr1Ovf), .tmr2Ovf(tmr2Ovf), .tmr3Ovf(tmr3Ovf),
    .extStart(extStart), .cmpIn(cmpIn), .eocIntEn(eocIntEn),
    .winIntEn(winIntEn), .winInside(winInside), .winLow(winLow),
    .winHigh(winHigh), .winClr(winClr), .dacCode(dacCode), .busy(busy),
    .result(result), .done(done), .eocIrq(eocIrq), .winIrq(winIrq)
  );

  // Vector table: source, input, low, high, inside mode, expected window flag
  localparam int VSEL [NV] = '{0, 1, 2, 3, 4, 5, 0, 3};
  localparam int VIN  [NV] = '{300, 200, 401, 401, 400, 1023, 0, 682};
  localparam int VLO  [NV] = '{200, 200, 200, 200, 200, 0, 0, 100};
  localparam int VHI  [NV] = '{400, 400, 400, 400, 400, 1022, 0, 600};
  localparam int VINS [NV] = '{1, 1, 1, 0, 0, 0, 1, 1};
  localparam int VEXP [NV] = '{1, 1, 0, 1, 0, 1, 1, 0};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Pulse the input belonging to a source code for one cycle
  task automatic pulseSrc(input int code);
    case (code)
      0: swStart = 1;
      1: tmr0Ovf = 1;
      2: tmr2Ovf = 1;
      3: tmr1Ovf = 1;
      4: extStart = 1;
      5: tmr3Ovf = 1;
      default: ;
    endcase
    tick(1);
    swStart = 0; tmr0Ovf = 0; tmr1Ovf = 0; tmr2Ovf = 0; tmr3Ovf = 0; extStart = 0;
  endtask

  task automatic pulseAll();
    swStart = 1; tmr0Ovf = 1; tmr1Ovf = 1; tmr2Ovf = 1; tmr3Ovf = 1; extStart = 1;
    tick(1);
    swStart = 0; tmr0Ovf = 0; tmr1Ovf = 0; tmr2Ovf = 0; tmr3Ovf = 0; extStart = 0;
  endtask

  // Wait for busy, then for done; returns busy length in cycles
  task automatic waitConv(output bit started, output int busyLen);
    started = 0;
    busyLen = 0;
    for (int i = 0; i < 8; i++) begin
      if (busy) begin started = 1; break; end
      tick(1);
    end
    if (started) begin
      for (int i = 0; i < 200; i++) begin
        if (!busy) break;
        busyLen++;
        tick(1);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    bit st;
    int len;
    tick(3);
    rstN = 1;
    tick(1);
    // Reset state
    chk(!busy && !done && result == 0 && !eocIrq && !winIrq, "R6 reset", {busy, done, eocIrq, winIrq}, 0);

    enable = 1;
    winIntEn = 1;

    // Vector walk: R1 sources, R4 result, R7 interrupt, R8 window
    for (int v = 0; v < NV; v++) begin
      startSel = 3'(VSEL[v]);
      vin = W'(VIN[v]);
      winLow = W'(VLO[v]);
      winHigh = W'(VHI[v]);
      winInside = VINS[v][0];
      eocIntEn = (v % 2 == 0);
      winClr = 1; tick(1); winClr = 0;
      pulseSrc(VSEL[v]);
      waitConv(st, len);
      chk(st, "R1 source start", v, 1);
      chk(done && result == vin, "R4 result", result, vin);
      chk(eocIrq == eocIntEn, "R7 eoc pulse", eocIrq, eocIntEn);
      chk(winIrq == VEXP[v][0], "R8 window", winIrq, VEXP[v]);
      tick(1);
      chk(!eocIrq, "R7 single cycle", eocIrq, 0);
    end

    // R4: MSB-first trial and conversion length
    startSel = 3'b000; vin = 10'd77;
    swStart = 1; tick(1); swStart = 0;
    chk(busy && dacCode == 10'd512, "R4 first trial", dacCode, 512);
    waitConv(st, len);
    chk(len == 10 * DIV, "R4 busy length", len, 10 * DIV);
    chk(result == 10'd77, "R4 result 77", result, 77);

    // R5 / R6: retrigger ignored, result held mid conversion
    vin = 10'd900;
    swStart = 1; tick(1); swStart = 0;
    tick(5);
    chk(result == 10'd77 && !done, "R6 result held", result, 77);
    swStart = 1; tick(1); swStart = 0;
    waitConv(st, len);
    chk(len == 10 * DIV - 6, "R5 retrigger ignored", len, 10 * DIV - 6);
    tick(4);
    chk(!busy && result == 10'd900, "R5 idle after", busy, 0);

    // R2: reserved codes
    for (int c = 6; c < 8; c++) begin
      startSel = 3'(c);
      pulseAll();
      tick(6);
      chk(!busy && done, "R2 reserved code", busy, 0);
    end

    // R1: unselected source ignored
    startSel = 3'b001;
    pulseSrc(2);
    tick(4);
    chk(!busy, "R1 wrong source", busy, 0);

    // R3: disabled ignores triggers, abort mid conversion
    enable = 0;
    startSel = 3'b000;
    swStart = 1; tick(3); swStart = 0;
    chk(!busy, "R3 disabled", busy, 0);
    enable = 1;
    vin = 10'd5;
    swStart = 1; tick(1); swStart = 0;
    tick(8);
    enable = 0;
    tick(2);
    chk(!busy && !done && result == 10'd900, "R3 abort", result, 900);
    tick(50);
    chk(!done && result == 10'd900, "R3 no latch", result, 900);
    enable = 1;

    // R9: level held high starts only once
    startSel = 3'b001; vin = 10'd321;
    tmr0Ovf = 1;
    tick(1);
    waitConv(st, len);
    chk(st && result == 10'd321, "R9 edge start", result, 321);
    tick(10);
    chk(!busy, "R9 level no restart", busy, 0);
    tmr0Ovf = 0;
    tick(2);

    // R8: sticky flag, clear, and disabled window interrupt
    winIntEn = 1; winInside = 1; winLow = 10'd0; winHigh = 10'd100;
    winClr = 1; tick(1); winClr = 0;
    startSel = 3'b000; vin = 10'd50;
    pulseSrc(0); waitConv(st, len);
    chk(winIrq, "R8 set", winIrq, 1);
    vin = 10'd500;
    pulseSrc(0); waitConv(st, len);
    chk(winIrq, "R8 sticky", winIrq, 1);
    winClr = 1; tick(1); winClr = 0;
    chk(!winIrq, "R8 clear", winIrq, 0);
    winIntEn = 0; vin = 10'd10;
    pulseSrc(0); waitConv(st, len);
    chk(!winIrq, "R8 disabled", winIrq, 0);

    // R10: continuous mode restarts on its own
    startSel = 3'b110; vin = 10'd640;
    contMode = 1;
    waitConv(st, len);
    chk(st && result == 10'd640, "R10 auto start", result, 640);
    tick(2);
    chk(busy, "R10 restart", busy, 1);
    contMode = 0;
    waitConv(st, len);
    tick(4);
    chk(!busy, "R10 stop", busy, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule